// File: doc/BRIEF.md
# Banked RAM and ROM Memory Subsystem

An 8-bit memory subsystem on a 10-bit byte address. A fixed decoder splits the space into two regions on the top address bit: the lower half is four 128-byte RAM banks, chosen by the next two address bits, and the upper half is a single 512-byte ROM. The ROM contents are not stored. A function in the shared package computes them.

The block takes one access per clock. The caller drives an address with a read strobe, a write strobe, or both. Writes land in the selected RAM bank on the clock edge. Read data is registered and appears one cycle after the read strobe. Each chip produces data only while its own select is active. An OR of the gated outputs forms the shared read path. A write aimed at the ROM changes nothing and raises a one-cycle flag.

Top module: `mem_subsys`

## Requirements
- R1: Address bit 9 = 0 selects a RAM bank, and bits 8:7 give the bank number. Bank 0 is 0x000–0x07F, bank 1 is 0x080–0x0FF, bank 2 is 0x100–0x17F and bank 3 is 0x180–0x1FF. Address bit 9 = 1 selects the ROM at 0x200–0x3FF.
- R2: `cs_o` bit i (0..3) is the select for RAM bank i and bit 4 is the ROM select. Exactly one bit is high while `re_i` or `we_i` is high, and all bits are low when neither strobe is high.
- R3: A write to RAM stores `wdata_i` at offset addr[6:0] of the selected bank. Every other bank and offset keeps its value.
- R4: Read data for an access appears on `rdata_o` at the clock edge that ends the access cycle, and it holds until the next edge.
- R5: `rdata_o` is 0 after any cycle in which `re_i` was low.
- R6: The ROM byte at offset k = addr[8:0] equals (7*k + 3) mod 256.
- R7: A write to the ROM region leaves the ROM contents unchanged.
- R8: `rom_wr_o` is high for exactly the one cycle after a cycle with `we_i` high and address bit 9 = 1. It is low at all other times.
- R9: When a read and a write hit the same RAM address in one cycle, the read returns the old content.
- R10: While `rst_ni` is low, `rdata_o` and `rom_wr_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 10 | Byte address |
| re_i | input | 1 | Read strobe |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| cs_o | output | 5 | Chip selects: bits 3:0 RAM banks, bit 4 ROM |
| rom_wr_o | output | 1 | One-cycle flag for a write to the ROM |

## Verification
The bench uses the default parameters: four banks of 128 bytes and a 512-byte ROM. With these values the whole 10-bit map can be reached. The bench drives the first and last address of every region to check that each select switches exactly on the range edges. It writes the same offset in all four banks to show that the banks are independent. It also covers a ROM write and a read and write in the same cycle.

// File: rtl/mem_pkg.sv
package mem_pkg;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned RAM_AW  = 7;
  localparam int unsigned N_BANKS = 4;
  localparam int unsigned BANK_W  = $clog2(N_BANKS);
  localparam int unsigned ROM_AW  = RAM_AW + BANK_W;
  localparam int unsigned ADDR_W  = ROM_AW + 1;

  // ROM content rule: byte k = 7k + 3, truncated to the data width
  function automatic logic [DATA_W-1:0] rom_byte(input int unsigned k);
    int unsigned v;
    v = k * 7 + 3;
    return v[DATA_W-1:0];
  endfunction
endpackage

// File: rtl/mem_addr_dec.sv
module mem_addr_dec #(
  parameter int unsigned RAM_AW  = mem_pkg::RAM_AW,
  parameter int unsigned N_BANKS = mem_pkg::N_BANKS,
  localparam int unsigned BANK_W = $clog2(N_BANKS),
  localparam int unsigned AW     = RAM_AW + BANK_W + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [AW-1:0]      addr_i,
  input  logic               re_i,
  input  logic               we_i,
  output logic [N_BANKS:0]   cs_o
);
  logic              access;
  logic              rom_region;
  logic [BANK_W-1:0] bank_id;

  assign access     = re_i | we_i;
  assign rom_region = addr_i[AW-1];
  assign bank_id    = addr_i[AW-2 -: BANK_W];

  for (genvar g = 0; g < N_BANKS; g++) begin : g_bank_cs
    assign cs_o[g] = access & ~rom_region & (bank_id == BANK_W'(g));
  end
  assign cs_o[N_BANKS] = access & rom_region;

  assert_one_select_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i || we_i) |-> ($countones(cs_o) == 1));
  assert_no_select_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(re_i || we_i) |-> (cs_o == '0));
  assert_rom_region_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && addr_i[AW-1]) |-> cs_o[N_BANKS]);
endmodule

// File: rtl/mem_ram_bank.sv
module mem_ram_bank #(
  parameter int unsigned AW = mem_pkg::RAM_AW,
  parameter int unsigned DW = mem_pkg::DATA_W,
  localparam int unsigned DEPTH = 1 << AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (cs_i && we_i) mem_q[addr_i] <= wdata_i;
  end

  // gated output: unselected bank contributes nothing to the shared path
  assign rdata_o = cs_i ? mem_q[addr_i] : '0;

  assert_write_lands_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && we_i) |=> (mem_q[$past(addr_i)] == $past(wdata_i)));
endmodule

// File: rtl/mem_rom.sv
module mem_rom #(
  parameter int unsigned AW = mem_pkg::ROM_AW,
  parameter int unsigned DW = mem_pkg::DATA_W
) (
  input  logic          cs_i,
  input  logic [AW-1:0] addr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] word;

  always_comb word = DW'(mem_pkg::rom_byte(32'(addr_i)));
  assign rdata_o = cs_i ? word : '0;
endmodule

// File: rtl/mem_subsys.sv
module mem_subsys #(
  parameter int unsigned DATA_W  = mem_pkg::DATA_W,
  parameter int unsigned RAM_AW  = mem_pkg::RAM_AW,
  parameter int unsigned N_BANKS = mem_pkg::N_BANKS,
  localparam int unsigned BANK_W = $clog2(N_BANKS),
  localparam int unsigned ROM_AW = RAM_AW + BANK_W,
  localparam int unsigned AW     = ROM_AW + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     addr_i,
  input  logic              re_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [N_BANKS:0]  cs_o,
  output logic              rom_wr_o
);
  logic [DATA_W-1:0] chip_rd [N_BANKS+1];
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rdata_q;
  logic              rom_wr_q;

  mem_addr_dec #(.RAM_AW(RAM_AW), .N_BANKS(N_BANKS)) u_dec (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .addr_i(addr_i),
    .re_i  (re_i),
    .we_i  (we_i),
    .cs_o  (cs_o)
  );

  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    mem_ram_bank #(.AW(RAM_AW), .DW(DATA_W)) u_bank (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cs_i   (cs_o[b]),
      .we_i   (we_i),
      .addr_i (addr_i[RAM_AW-1:0]),
      .wdata_i(wdata_i),
      .rdata_o(chip_rd[b])
    );
  end

  mem_rom #(.AW(ROM_AW), .DW(DATA_W)) u_rom (
    .cs_i   (cs_o[N_BANKS]),
    .addr_i (addr_i[ROM_AW-1:0]),
    .rdata_o(chip_rd[N_BANKS])
  );

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i <= N_BANKS; i++) rd_mux |= chip_rd[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rom_wr_q <= 1'b0;
    end else begin
      rdata_q  <= re_i ? rd_mux : '0;
      rom_wr_q <= we_i & addr_i[AW-1];
    end
  end

  assign rdata_o  = rdata_q;
  assign rom_wr_o = rom_wr_q;

  assert_idle_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> (rdata_o == '0));
  assert_rom_read_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && addr_i[AW-1]) |=>
      (rdata_o == DATA_W'(mem_pkg::rom_byte(32'($past(addr_i[ROM_AW-1:0]))))));
  assert_rom_wr_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i[AW-1]) |=> rom_wr_o);
  assert_rom_wr_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i[AW-1]) |=> !rom_wr_o);
  always_comb begin
    if (!rst_ni) assert_reset_R10: assert (rdata_o == '0 && !rom_wr_o);
  end
endmodule

// File: tb/sim_mem_subsys.sv
`timescale 1ns/1ps
module sim_mem_subsys;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] addr = '0;
  logic       re = 1'b0, we = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [4:0] cs;
  logic       rom_wr;

  int checks = 0, errors = 0;
  logic [7:0] ram_m [512];
  logic [4:0] last_cs;

  always #2.5 clk = ~clk;

  mem_subsys u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .re_i(re), .we_i(we),
    .wdata_i(wdata), .rdata_o(rdata), .cs_o(cs), .rom_wr_o(rom_wr)
  );

  function automatic logic [7:0] exp_rom(input int k);
    return 8'((k * 7 + 3) % 256);
  endfunction

  function automatic logic [4:0] exp_cs(input logic [9:0] a);
    if (a[9]) return 5'b10000;
    return 5'(1 << a[8:7]);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic access(input logic [9:0] a, input logic r, input logic w, input logic [7:0] d);
    @(negedge clk);
    addr = a; re = r; we = w; wdata = d;
    #1 last_cs = cs;
    @(posedge clk);
    #1;
    re = 1'b0; we = 1'b0;
    if (w && !a[9]) ram_m[a[8:0]] = d;
  endtask

  task automatic t_reset;
    #1;
    chk("R10 rdata in reset", rdata, 0);
    chk("R10 rom_wr in reset", rom_wr, 0);
    chk("R2 no select idle", cs, 0);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
  endtask

  task automatic t_map;
    logic [9:0] edges [10] = '{10'h000, 10'h07F, 10'h080, 10'h0FF, 10'h100,
                               10'h17F, 10'h180, 10'h1FF, 10'h200, 10'h3FF};
    foreach (edges[i]) begin
      access(edges[i], 1'b1, 1'b0, 8'h00);
      chk("R1 select for address", last_cs, exp_cs(edges[i]));
      chk("R2 one select", $countones(last_cs), 1);
    end
    access(10'h2A0, 1'b0, 1'b0, 8'h00);
    chk("R2 no select without strobe", last_cs, 0);
  endtask

  task automatic t_ram;
    for (int b = 0; b < 4; b++) begin
      access(10'(b * 128 + 8'h15), 1'b0, 1'b1, 8'(8'hA0 + b));
      chk("R2 write select", last_cs, 5'(1 << b));
    end
    access(10'h07F, 1'b0, 1'b1, 8'h5C);
    access(10'h180, 1'b0, 1'b1, 8'hC3);
    for (int b = 0; b < 4; b++) begin
      access(10'(b * 128 + 8'h15), 1'b1, 1'b0, 8'h00);
      chk("R3 bank content", rdata, ram_m[b * 128 + 8'h15]);
    end
    access(10'h07F, 1'b1, 1'b0, 8'h00);
    chk("R3 bank0 top", rdata, 8'h5C);
    access(10'h180, 1'b1, 1'b0, 8'h00);
    chk("R4 read data after one edge", rdata, 8'hC3);
    @(negedge clk);
    chk("R4 read data held", rdata, 8'hC3);
  endtask

  task automatic t_rom;
    int offs [5] = '{0, 1, 255, 256, 511};
    foreach (offs[i]) begin
      access(10'(512 + offs[i]), 1'b1, 1'b0, 8'h00);
      chk("R6 rom byte", rdata, exp_rom(offs[i]));
    end
  endtask

  task automatic t_rom_wr;
    access(10'h205, 1'b0, 1'b1, 8'hFF);
    chk("R8 flag after rom write", rom_wr, 1);
    chk("R5 no read data on write", rdata, 0);
    access(10'h205, 1'b1, 1'b0, 8'h00);
    chk("R8 flag one cycle", rom_wr, 0);
    chk("R7 rom unchanged", rdata, exp_rom(5));
    access(10'h011, 1'b0, 1'b1, 8'h77);
    chk("R8 no flag on ram write", rom_wr, 0);
  endtask

  task automatic t_idle;
    access(10'h011, 1'b1, 1'b0, 8'h00);
    chk("R3 ram read", rdata, 8'h77);
    access(10'h011, 1'b0, 1'b0, 8'h00);
    chk("R5 idle gives zero", rdata, 0);
  endtask

  task automatic t_rdw;
    logic [7:0] old_v;
    access(10'h0AA, 1'b0, 1'b1, 8'h11);
    old_v = ram_m[10'h0AA];
    access(10'h0AA, 1'b1, 1'b1, 8'h22);
    chk("R9 read returns old", rdata, old_v);
    access(10'h0AA, 1'b1, 1'b0, 8'h00);
    chk("R9 new value stored", rdata, 8'h22);
  endtask

  initial begin
    #100000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_map();
    t_ram();
    t_rom();
    t_rom_wr();
    t_idle();
    t_rdw();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule